// File: doc/BRIEF.md
# Command Completion Coalescing Interrupt Unit

This unit sits beside a group of storage host ports and turns many command-completion events into fewer interrupts. Each port reports a one-cycle completion pulse per finished command and a bitmap of the command slots it still has in flight. Software picks the ports that take part with a selection mask and programs a completion threshold. The unit adds up completions from the chosen ports, and when the running total reaches the threshold it raises one coalesced interrupt and starts counting again from zero.

The unit does not hold back the last completions of a burst. If a counted completion leaves no slot busy on any chosen port, it fires at once, even when the threshold has not been reached. A threshold of one gives an interrupt for every completing command, and a threshold of zero switches the feature off. The interrupt is held in a sticky status bit that software clears by writing one to it. A one-cycle pulse output marks each firing event, so firings that happen while the status bit is already set can still be seen.

Top module: `ccc_coalesce_top`

## Requirements
- R1: Completion pulses on ports whose bit in `port_sel` is 0 do not change `cmpl_count` and never cause a firing.
- R2: When several selected ports complete in the same cycle, `cmpl_count` grows by the number of those ports in one step.
- R3: When a cycle's counted completions bring the total to the threshold or above, `irq_pulse` is 1 for the next cycle and `cmpl_count` returns to 0 in that same cycle.
- R4: With `threshold` = 1, every cycle with at least one selected completion produces a firing.
- R5: A cycle with at least one selected completion fires, whatever the total, when no slot bit is set in `busy_slots` for any selected port (port p owns bits p*SLOTS to p*SLOTS+SLOTS-1). Busy slots on unselected ports are ignored, and an idle set of ports with no completion does not fire.
- R6: While `threshold` = 0, `cmpl_count` is forced to 0 on the next edge and no firing happens.
- R7: `irq_status` becomes 1 on every firing and stays 1 until a cycle with `irq_ack` = 1 and no firing. A firing in the same cycle as `irq_ack` leaves it at 1. It only rises on a firing.
- R8: A synchronous reset (`rst` = 1) clears `cmpl_count`, `irq_pulse` and `irq_status` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_sel | input | NPORTS | Ports that take part in coalescing |
| threshold | input | THR_W | Completions per interrupt; 0 disables |
| cmpl_evt | input | NPORTS | One-cycle completion pulse per port |
| busy_slots | input | NPORTS*SLOTS | In-flight command slot bitmap of each port |
| irq_ack | input | 1 | Write-one-to-clear of the status bit |
| irq_status | output | 1 | Sticky coalesced interrupt |
| irq_pulse | output | 1 | One-cycle marker of each firing |
| cmpl_count | output | THR_W | Current completion total |

## Verification
The bench sends completions only on unselected ports, then mixed masks, to show that only selected ports are counted. It sends several selected ports in one cycle to show that counts add in a single step, and runs a total past the threshold to show wrap to zero. Busy maps are tried with slots busy only on unselected ports, only on selected ports, and with none busy and no completion. Together these separate an early idle firing from a threshold firing and from a wrong firing. Threshold one and zero and software clears that meet a firing in the same cycle cover the limit cases.

// File: rtl/ccc_pkg.sv
package ccc_pkg;

    parameter int unsigned CCC_NPORTS = 8;
    parameter int unsigned CCC_THR_W  = 8;
    parameter int unsigned CCC_SLOTS  = 32;

    // Decision taken by the counter for one cycle
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,  // no counted completion
        ACT_ACCUM = 2'd1,  // add completions, below threshold, ports busy
        ACT_FIRE  = 2'd2,  // threshold reached or ports idle
        ACT_FLUSH = 2'd3   // feature disabled
    } ccc_act_e;

    // Population count of up to 64 event bits
    function automatic int unsigned count_ones(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            n = n + {31'd0, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/ccc_port_filter.sv
module ccc_port_filter #(
    parameter int unsigned NPORTS = ccc_pkg::CCC_NPORTS,
    parameter int unsigned SLOTS  = ccc_pkg::CCC_SLOTS
) (
    input  logic [NPORTS-1:0]       port_sel,
    input  logic [NPORTS-1:0]       cmpl_evt,
    input  logic [NPORTS*SLOTS-1:0] busy_slots,
    output logic [NPORTS-1:0]       sel_evt,
    output logic                    sel_idle
);
    logic [NPORTS-1:0] port_busy;

    // Reduce each port's slot bitmap to one busy flag
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign port_busy[p] = |busy_slots[p*SLOTS +: SLOTS];
    end

    assign sel_evt  = cmpl_evt & port_sel;
    assign sel_idle = ~|(port_busy & port_sel);
endmodule

// File: rtl/ccc_counter.sv
module ccc_counter
    import ccc_pkg::*;
#(
    parameter int unsigned NPORTS = ccc_pkg::CCC_NPORTS,
    parameter int unsigned THR_W  = ccc_pkg::CCC_THR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORTS-1:0] sel_evt,
    input  logic              sel_idle,
    input  logic [THR_W-1:0]  threshold,
    output logic              fire_now,
    output logic              fire_pulse,
    output logic [THR_W-1:0]  count
);
    localparam int unsigned CW = $clog2(NPORTS + 1);
    localparam int unsigned SW = ((THR_W > CW) ? THR_W : CW) + 1;

    logic [CW-1:0]    inc;
    logic [SW-1:0]    sum;
    logic             enabled;
    logic             reached;
    ccc_act_e         act;
    logic [THR_W-1:0] count_d;

    always_comb begin
        inc     = CW'(count_ones(64'(sel_evt)));
        sum     = SW'(count) + SW'(inc);
        enabled = (threshold != '0);
        reached = (sum >= SW'(threshold));
        if (!enabled)
            act = ACT_FLUSH;
        else if (inc == '0)
            act = ACT_HOLD;
        else if (reached || sel_idle)
            act = ACT_FIRE;
        else
            act = ACT_ACCUM;
    end

    always_comb begin
        unique case (act)
            ACT_FLUSH: count_d = '0;
            ACT_FIRE:  count_d = '0;
            ACT_ACCUM: count_d = THR_W'(sum);
            default:   count_d = count;
        endcase
    end

    assign fire_now = (act == ACT_FIRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count      <= '0;
            fire_pulse <= 1'b0;
        end else begin
            count      <= count_d;
            fire_pulse <= fire_now;
        end
    end
endmodule

// File: rtl/ccc_irq_status.sv
module ccc_irq_status (
    input  logic clk,
    input  logic rst,
    input  logic fire_now,
    input  logic ack,
    output logic status
);
    // Setting takes priority over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            status <= 1'b0;
        else if (fire_now)
            status <= 1'b1;
        else if (ack)
            status <= 1'b0;
    end
endmodule

// File: rtl/ccc_coalesce_top.sv
module ccc_coalesce_top #(
    parameter int unsigned NPORTS = ccc_pkg::CCC_NPORTS,
    parameter int unsigned THR_W  = ccc_pkg::CCC_THR_W,
    parameter int unsigned SLOTS  = ccc_pkg::CCC_SLOTS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORTS-1:0]       port_sel,
    input  logic [THR_W-1:0]        threshold,
    input  logic [NPORTS-1:0]       cmpl_evt,
    input  logic [NPORTS*SLOTS-1:0] busy_slots,
    input  logic                    irq_ack,
    output logic                    irq_status,
    output logic                    irq_pulse,
    output logic [THR_W-1:0]        cmpl_count
);
    logic [NPORTS-1:0] sel_evt;
    logic              sel_idle;
    logic              fire_now;

    ccc_port_filter #(.NPORTS(NPORTS), .SLOTS(SLOTS)) u_filter (
        .port_sel   (port_sel),
        .cmpl_evt   (cmpl_evt),
        .busy_slots (busy_slots),
        .sel_evt    (sel_evt),
        .sel_idle   (sel_idle)
    );

    ccc_counter #(.NPORTS(NPORTS), .THR_W(THR_W)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .sel_evt    (sel_evt),
        .sel_idle   (sel_idle),
        .threshold  (threshold),
        .fire_now   (fire_now),
        .fire_pulse (irq_pulse),
        .count      (cmpl_count)
    );

    ccc_irq_status u_status (
        .clk      (clk),
        .rst      (rst),
        .fire_now (fire_now),
        .ack      (irq_ack),
        .status   (irq_status)
    );
endmodule

// File: rtl/ccc_checker.sv
module ccc_checker #(
    parameter int unsigned NPORTS = 8,
    parameter int unsigned THR_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NPORTS-1:0] port_sel,
    input logic [THR_W-1:0]  threshold,
    input logic [NPORTS-1:0] cmpl_evt,
    input logic              irq_ack,
    input logic              irq_status,
    input logic              irq_pulse,
    input logic [THR_W-1:0]  cmpl_count
);
    assert_unselected_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        ((cmpl_evt & port_sel) == '0) |=> !irq_pulse);

    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (cmpl_count == '0));

    assert_every_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        (threshold == THR_W'(1) && (cmpl_evt & port_sel) != '0) |=> irq_pulse);

    assert_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        (threshold == '0) |=> (cmpl_count == '0 && !irq_pulse));

    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_status && !irq_ack) |=> irq_status);

    assert_set_on_fire_R7: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> irq_status);

    assert_rise_only_on_fire_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_status) |-> irq_pulse);
endmodule

bind ccc_coalesce_top ccc_checker #(.NPORTS(NPORTS), .THR_W(THR_W)) u_ccc_checker (
    .clk        (clk),
    .rst        (rst),
    .port_sel   (port_sel),
    .threshold  (threshold),
    .cmpl_evt   (cmpl_evt),
    .irq_ack    (irq_ack),
    .irq_status (irq_status),
    .irq_pulse  (irq_pulse),
    .cmpl_count (cmpl_count)
);

// File: tb/tb_ccc_coalesce_top.sv
module tb_ccc_coalesce_top;
    localparam int NP = 8;
    localparam int TW = 8;
    localparam int SL = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP-1:0]     port_sel = '0;
    logic [TW-1:0]     threshold = '0;
    logic [NP-1:0]     cmpl_evt = '0;
    logic [NP*SL-1:0]  busy_slots = '0;
    logic              irq_ack = 1'b0;
    logic              irq_status;
    logic              irq_pulse;
    logic [TW-1:0]     cmpl_count;

    always #5 clk = ~clk;

    ccc_coalesce_top #(.NPORTS(NP), .THR_W(TW), .SLOTS(SL)) dut (
        .clk(clk), .rst(rst), .port_sel(port_sel), .threshold(threshold),
        .cmpl_evt(cmpl_evt), .busy_slots(busy_slots), .irq_ack(irq_ack),
        .irq_status(irq_status), .irq_pulse(irq_pulse), .cmpl_count(cmpl_count)
    );

    typedef struct {
        int    cnt;
        bit    pulse;
        bit    irq;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // Reference state built from the requirements
    int m_cnt = 0;
    bit m_irq = 1'b0;

    function automatic logic [NP*SL-1:0] busy_map(input logic [NP-1:0] ports);
        logic [NP*SL-1:0] m;
        m = '0;
        for (int p = 0; p < NP; p++)
            if (ports[p]) m[p*SL + 3] = 1'b1;
        return m;
    endfunction

    task automatic step(input logic [NP-1:0] sel, input int thr,
                        input logic [NP-1:0] evt, input logic [NP-1:0] busy_ports,
                        input bit ack, input string tag);
        exp_t e;
        int   n;
        bit   idle;
        bit   fire;
        @(negedge clk);
        port_sel   = sel;
        threshold  = TW'(thr);
        cmpl_evt   = evt;
        busy_slots = busy_map(busy_ports);
        irq_ack    = ack;
        n = 0;
        for (int p = 0; p < NP; p++) if (evt[p] && sel[p]) n++;
        idle = ((busy_ports & sel) == '0);
        fire = (thr != 0) && (n > 0) && ((m_cnt + n >= thr) || idle);
        if (thr == 0)  m_cnt = 0;
        else if (fire) m_cnt = 0;
        else           m_cnt = m_cnt + n;
        if (fire)      m_irq = 1'b1;
        else if (ack)  m_irq = 1'b0;
        e.cnt = m_cnt; e.pulse = fire; e.irq = m_irq; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare each expected item one step after the edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (int'(cmpl_count) != e.cnt || irq_pulse != e.pulse || irq_status != e.irq) begin
                    errors++;
                    $display("FAIL %s: cnt=%0d pulse=%0b irq=%0b expected cnt=%0d pulse=%0b irq=%0b",
                             e.tag, cmpl_count, irq_pulse, irq_status, e.cnt, e.pulse, e.irq);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (cmpl_count != '0 || irq_pulse || irq_status) begin
            errors++;
            $display("FAIL R8 reset: cnt=%0d pulse=%0b irq=%0b expected 0 0 0",
                     cmpl_count, irq_pulse, irq_status);
        end
        rst = 1'b0;

        // Threshold 4, ports 0..3 selected, port 0 busy
        step(8'h0F, 4, 8'h20, 8'h01, 0, "R1 unselected completion ignored");
        step(8'h0F, 4, 8'hF3, 8'h01, 0, "R2 two selected in one cycle");
        step(8'h0F, 4, 8'h01, 8'h01, 0, "R2 accumulate");
        step(8'h0F, 4, 8'h06, 8'h01, 0, "R3 threshold crossed");
        step(8'h0F, 4, 8'h00, 8'h01, 0, "R7 status held");
        step(8'h0F, 4, 8'h00, 8'h01, 1, "R7 ack clears");
        step(8'h0F, 4, 8'h0F, 8'h01, 1, "R7 fire wins over ack");
        step(8'h0F, 4, 8'h00, 8'h01, 1, "R7 ack clears again");
        // Idle firing
        step(8'h0F, 4, 8'h02, 8'h40, 0, "R5 idle fire, unselected busy ignored");
        step(8'h0F, 4, 8'h00, 8'h00, 1, "R5 idle without completion no fire");
        step(8'h0F, 4, 8'h80, 8'h40, 0, "R1 unselected completion no fire");
        step(8'h0F, 4, 8'h01, 8'h02, 0, "R5 selected busy blocks early fire");
        step(8'h0F, 4, 8'h01, 8'h02, 0, "R2 count two");
        // Threshold of one
        step(8'h0F, 1, 8'h04, 8'h02, 0, "R4 fire per completion");
        for (int i = 0; i < 4; i++)
            step(8'h0F, 1, 8'(1 << i), 8'h0F, 1, "R4 repeated completions");
        step(8'h0F, 1, 8'h00, 8'h0F, 1, "R4 no completion no fire");
        // Disabled
        step(8'h0F, 4, 8'h01, 8'h01, 0, "R2 build count");
        step(8'h0F, 0, 8'h00, 8'h01, 0, "R6 disable flushes count");
        step(8'h0F, 0, 8'h0F, 8'h00, 0, "R6 no fire while disabled");
        step(8'h0F, 0, 8'h0F, 8'h01, 0, "R6 still disabled");
        step(8'hF0, 3, 8'hF0, 8'hFF, 0, "R2 four upper ports");
        step(8'hF0, 3, 8'h00, 8'hFF, 0, "R3 after wrap idle");

        // Reset with status set
        step(8'hF0, 3, 8'h10, 8'h00, 0, "R5 idle fire before reset");
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        checks++;
        if (cmpl_count != '0 || irq_pulse || irq_status) begin
            errors++;
            $display("FAIL R8 reset mid-run: cnt=%0d pulse=%0b irq=%0b expected 0 0 0",
                     cmpl_count, irq_pulse, irq_status);
        end
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule